// File: doc/BRIEF.md
# PWM Periodic Comparison Unit

A bank of independent comparators that watch one shared reference PWM counter and fire a one-clock match pulse when the counter reaches a programmed value. Each comparator has its own period prescaler. It can be told to act only in one selected period out of every N counter periods. It can also be told to fire only while the counter rises or only while it falls when the counter runs center aligned. An active fault on the reference channel blocks all comparisons.

Each comparator has two configuration groups. The mode group holds enable, target period and prescaler limit. The value group holds the compare value and the direction select. Each group has a direct write port that takes effect at once, and a shadow write port that is held pending and applied on the next period-end strobe, so a running comparison never sees half-old, half-new settings. Match pulses feed a shared event line, per-unit sticky interrupt flags, and a DMA request line gated by a per-unit mask parameter.

Top module: `pwm_cmp_bank`

## Requirements
- R1: For unit i, `match_o[i]` is high in the cycle after a cycle in which all of these hold: the unit is enabled, `cnt_i` equals the unit's compare value, the direction condition (R3) holds, the fault input is low (R4), and the period counter equals the target period (R5). Otherwise `match_o[i]` is low.
- R2: A match is one clock long. If the match condition holds over several consecutive cycles, only its first cycle produces a pulse.
- R3: With `center_i`=1, a direction select of 0 allows matches only while `cnt_down_i`=0, and 1 only while `cnt_down_i`=1. With `center_i`=0 the direction select has no effect.
- R4: While `fault_i` is high no unit can match.
- R5: Each unit has a period counter. It steps on every `period_end_i` and returns to 0 on the strobe where it already equals or exceeds the prescaler limit. Comparison is allowed only while this counter equals the target period, so a target above the limit never matches.
- R6: With both target period and limit at 0, the unit can match in every period.
- R7: A direct write (`mode_wr_i[i]` or `val_wr_i[i]`) replaces the active fields at the next clock edge. A direct mode write also sets the period counter to 0.
- R8: A shadow write (`mode_upd_i[i]` or `val_upd_i[i]`) has no effect on matching until the next `period_end_i`. Its data is copied at that edge. A shadow write made in the same cycle as a strobe stays pending for the following strobe.
- R9: `irq_o[i]` rises together with `match_o[i]` and stays high until `irq_clr_i[i]` is sampled high. A match in the clearing cycle wins.
- R10: `event_o` is the OR of all match pulses. `dma_req_o` is the OR of the match pulses of the units selected by parameter `DMA_UNITS`.
- R11: After reset all outputs are 0, all units are disabled with zero fields, and all period counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Reference counter value |
| cnt_down_i | input | 1 | Reference counter is decrementing |
| center_i | input | 1 | Reference counter is center aligned |
| period_end_i | input | 1 | Reference period-end strobe |
| fault_i | input | 1 | Fault active on reference channel |
| mode_wr_i | input | N_UNITS | Direct mode write, one bit per unit |
| mode_upd_i | input | N_UNITS | Shadow mode write, one bit per unit |
| mode_en_i | input | 1 | Write data: enable |
| mode_ctr_i | input | 4 | Write data: target period |
| mode_cpr_i | input | 4 | Write data: prescaler limit |
| val_wr_i | input | N_UNITS | Direct value write, one bit per unit |
| val_upd_i | input | N_UNITS | Shadow value write, one bit per unit |
| val_cv_i | input | 16 | Write data: compare value |
| val_cvm_i | input | 1 | Write data: direction select (0 up, 1 down) |
| irq_clr_i | input | N_UNITS | Interrupt flag clear strobes |
| match_o | output | N_UNITS | One-clock match pulses |
| irq_o | output | N_UNITS | Sticky interrupt flags |
| event_o | output | 1 | Event line pulse |
| dma_req_o | output | 1 | DMA trigger request |

## Verification
The hardest case to reach from the ports is a unit whose period counter stands on its target period in the same cycle as a shadow update and a direct write race against a period-end strobe, because the period counter is only observable through whether matches appear. Directed sequences drive whole periods with the counter hitting the compare value once per period and count the pulses across many periods. Long random runs, with small ranges for counter, compare value, target and limit, make these races frequent. A cycle model written from the requirements is compared with every output on every cycle.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int CNT_W = 16;
  localparam int PER_W = 4;

  typedef struct packed {
    logic             en;
    logic [PER_W-1:0] ctr;
    logic [PER_W-1:0] cpr;
  } cmp_mode_t;

  typedef struct packed {
    logic [CNT_W-1:0] cv;
    logic             cvm;
  } cmp_val_t;
endpackage

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter type T = logic
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic upd_i,
  input  T     data_i,
  input  logic apply_i,
  output T     act_o
);
  T     act_q, shd_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      // direct write beats a pending copy
      if (wr_i)                 act_q <= data_i;
      else if (apply_i && pend_q) act_q <= shd_q;
      if (upd_i) shd_q <= data_i;
      pend_q <= upd_i | (pend_q & ~apply_i);
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             center_i,
  input  logic             period_end_i,
  input  logic             fault_i,
  input  cmp_mode_t        mode_i,
  input  cmp_val_t         val_i,
  input  logic             restart_i,
  input  logic             irq_clr_i,
  output logic             match_o,
  output logic             irq_o
);
  logic [PER_W-1:0] prd_q;
  logic dir_ok, prd_ok, hit, hit_q, rise, match_q, irq_q;

  assign dir_ok = ~center_i | (val_i.cvm == cnt_down_i);
  assign prd_ok = (prd_q == mode_i.ctr);
  assign hit    = mode_i.en & (cnt_i == val_i.cv) & dir_ok & ~fault_i & prd_ok;
  assign rise   = hit & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q   <= '0;
      hit_q   <= 1'b0;
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (restart_i)         prd_q <= '0;
      else if (period_end_i) prd_q <= (prd_q >= mode_i.cpr) ? '0 : prd_q + 1'b1;
      hit_q   <= hit;
      match_q <= rise;
      irq_q   <= (irq_q & ~irq_clr_i) | rise;
    end
  end

  assign match_o = match_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
  import pwm_cmp_pkg::*;
#(
  parameter int                 N_UNITS   = 8,
  parameter logic [N_UNITS-1:0] DMA_UNITS = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               cnt_down_i,
  input  logic               center_i,
  input  logic               period_end_i,
  input  logic               fault_i,
  input  logic [N_UNITS-1:0] mode_wr_i,
  input  logic [N_UNITS-1:0] mode_upd_i,
  input  logic               mode_en_i,
  input  logic [PER_W-1:0]   mode_ctr_i,
  input  logic [PER_W-1:0]   mode_cpr_i,
  input  logic [N_UNITS-1:0] val_wr_i,
  input  logic [N_UNITS-1:0] val_upd_i,
  input  logic [CNT_W-1:0]   val_cv_i,
  input  logic               val_cvm_i,
  input  logic [N_UNITS-1:0] irq_clr_i,
  output logic [N_UNITS-1:0] match_o,
  output logic [N_UNITS-1:0] irq_o,
  output logic               event_o,
  output logic               dma_req_o
);
  cmp_mode_t mode_d;
  cmp_val_t  val_d;

  assign mode_d = '{en: mode_en_i, ctr: mode_ctr_i, cpr: mode_cpr_i};
  assign val_d  = '{cv: val_cv_i, cvm: val_cvm_i};

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    cmp_mode_t mode_act;
    cmp_val_t  val_act;

    pwm_cmp_shadow #(.T(cmp_mode_t)) u_mode (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (mode_wr_i[g]),
      .upd_i  (mode_upd_i[g]),
      .data_i (mode_d),
      .apply_i(period_end_i),
      .act_o  (mode_act)
    );

    pwm_cmp_shadow #(.T(cmp_val_t)) u_val (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (val_wr_i[g]),
      .upd_i  (val_upd_i[g]),
      .data_i (val_d),
      .apply_i(period_end_i),
      .act_o  (val_act)
    );

    pwm_cmp_unit u_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_i       (cnt_i),
      .cnt_down_i  (cnt_down_i),
      .center_i    (center_i),
      .period_end_i(period_end_i),
      .fault_i     (fault_i),
      .mode_i      (mode_act),
      .val_i       (val_act),
      .restart_i   (mode_wr_i[g]),
      .irq_clr_i   (irq_clr_i[g]),
      .match_o     (match_o[g]),
      .irq_o       (irq_o[g])
    );
  end

  assign event_o   = |match_o;
  assign dma_req_o = |(match_o & DMA_UNITS);
endmodule

// File: rtl/pwm_cmp_bank_chk.sv
module pwm_cmp_bank_chk #(
  parameter int N_UNITS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fault_i,
  input logic [N_UNITS-1:0] irq_clr_i,
  input logic [N_UNITS-1:0] match_o,
  input logic [N_UNITS-1:0] irq_o,
  input logic               event_o,
  input logic               dma_req_o
);
  AST_FAULT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_i) |-> (match_o == '0)); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((match_o & $past(match_o)) == '0)); // R2
  AST_IRQ_WITH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & match_o) == match_o)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~irq_o & $past(irq_o) & ~$past(irq_clr_i)) == '0)); // R9
  AST_DMA_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> event_o); // R10
  AST_EVENT_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (match_o != '0)); // R10
endmodule

bind pwm_cmp_bank pwm_cmp_bank_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fault_i  (fault_i),
  .irq_clr_i(irq_clr_i),
  .match_o  (match_o),
  .irq_o    (irq_o),
  .event_o  (event_o),
  .dma_req_o(dma_req_o)
);

// File: tb/pwm_cmp_bank_test.sv
module pwm_cmp_bank_test;
  import pwm_cmp_pkg::*;
  localparam int N = 8;
  localparam logic [N-1:0] DMA = 8'b0101_0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic down = 0, center = 0, pe = 0, fault = 0;
  logic [N-1:0] mwr = '0, mupd = '0, vwr = '0, vupd = '0, clr = '0;
  logic men = 0, cvm = 0;
  logic [PER_W-1:0] ctr = '0, cpr = '0;
  logic [CNT_W-1:0] cv = '0;
  logic [N-1:0] match, irq;
  logic ev, dma;

  always #10 clk = ~clk;

  pwm_cmp_bank #(.N_UNITS(N), .DMA_UNITS(DMA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(down), .center_i(center),
    .period_end_i(pe), .fault_i(fault), .mode_wr_i(mwr), .mode_upd_i(mupd),
    .mode_en_i(men), .mode_ctr_i(ctr), .mode_cpr_i(cpr), .val_wr_i(vwr),
    .val_upd_i(vupd), .val_cv_i(cv), .val_cvm_i(cvm), .irq_clr_i(clr),
    .match_o(match), .irq_o(irq), .event_o(ev), .dma_req_o(dma));

  int checks = 0, fails = 0, wd = 0, m0 = 0;
  string tag = "R1";
  bit monitor_on = 0;

  // reference model
  cmp_mode_t m_mode[N], m_mshd[N];
  cmp_val_t  m_val[N], m_vshd[N];
  logic m_mpend[N], m_vpend[N], m_hitq[N];
  logic [PER_W-1:0] m_prd[N];
  logic [N-1:0] m_match, m_irq;

  function automatic logic model_hit(int i);
    logic dir_ok;
    dir_ok = !center || (m_val[i].cvm == down);
    return m_mode[i].en && (cnt == m_val[i].cv) && dir_ok && !fault &&
           (m_prd[i] == m_mode[i].ctr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mode[i] <= '0; m_mshd[i] <= '0; m_val[i] <= '0; m_vshd[i] <= '0;
        m_mpend[i] <= 0; m_vpend[i] <= 0; m_hitq[i] <= 0; m_prd[i] <= '0;
      end
      m_match <= '0; m_irq <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic h, r;
        h = model_hit(i);
        r = h && !m_hitq[i];
        m_hitq[i]  <= h;
        m_match[i] <= r;
        m_irq[i]   <= (m_irq[i] && !clr[i]) || r;
        if (mwr[i]) m_mode[i] <= '{en: men, ctr: ctr, cpr: cpr};
        else if (pe && m_mpend[i]) m_mode[i] <= m_mshd[i];
        if (mupd[i]) m_mshd[i] <= '{en: men, ctr: ctr, cpr: cpr};
        m_mpend[i] <= mupd[i] || (m_mpend[i] && !pe);
        if (vwr[i]) m_val[i] <= '{cv: cv, cvm: cvm};
        else if (pe && m_vpend[i]) m_val[i] <= m_vshd[i];
        if (vupd[i]) m_vshd[i] <= '{cv: cv, cvm: cvm};
        m_vpend[i] <= vupd[i] || (m_vpend[i] && !pe);
        if (mwr[i]) m_prd[i] <= '0;
        else if (pe) m_prd[i] <= (m_prd[i] >= m_mode[i].cpr) ? '0 : m_prd[i] + 1'b1;
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (monitor_on) begin
    check(tag, "match_o", match, m_match);
    check("R9", "irq_o", irq, m_irq);
    check("R10", "event_o", ev, |m_match);
    check("R10", "dma_req_o", dma, |(m_match & DMA));
    if (match[0]) m0++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", wd);
      summary();
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic mode_dir(int i, logic e, int t, int p);
    men = e; ctr = PER_W'(t); cpr = PER_W'(p); mwr = N'(1) << i; cyc(1); mwr = '0;
  endtask
  task automatic val_dir(int i, int v, logic d);
    cv = CNT_W'(v); cvm = d; vwr = N'(1) << i; cyc(1); vwr = '0;
  endtask
  task automatic hold(int v, int n); cnt = CNT_W'(v); cyc(n); cnt = 16'hFFFF; cyc(2); endtask
  task automatic period(int v);
    cnt = CNT_W'(v); cyc(1); cnt = 16'hFFFF; cyc(1); pe = 1; cyc(1); pe = 0;
  endtask

  initial begin
    cnt = 16'hFFFF;
    #25 rst_n = 1;
    check("R11", "match_o after reset", match, 0);
    check("R11", "irq_o after reset", irq, 0);
    check("R11", "event/dma after reset", {ev, dma}, 0);
    cyc(1);
    monitor_on = 1;

    tag = "R7"; m0 = 0;
    mode_dir(0, 1, 0, 0); val_dir(0, 5, 0); hold(5, 1);
    check("R7", "direct write match count", m0, 1);

    tag = "R2"; m0 = 0; hold(5, 6);
    check("R2", "held counter pulses", m0, 1);

    tag = "R3"; center = 1;
    m0 = 0; down = 1; hold(5, 2); check("R3", "up-only while down", m0, 0);
    m0 = 0; down = 0; hold(5, 2); check("R3", "up-only while up", m0, 1);
    val_dir(0, 5, 1);
    m0 = 0; down = 1; hold(5, 2); check("R3", "down-only while down", m0, 1);
    m0 = 0; down = 0; hold(5, 2); check("R3", "down-only while up", m0, 0);
    center = 0; m0 = 0; hold(5, 2); check("R3", "left aligned ignores select", m0, 1);

    tag = "R4"; m0 = 0; fault = 1; hold(5, 3); check("R4", "fault blocks", m0, 0);
    fault = 0; m0 = 0; hold(5, 2); check("R4", "after fault", m0, 1);

    tag = "R9"; cyc(3); check("R9", "irq sticky", irq[0], 1);
    clr = 8'h01; cyc(1); clr = '0; cyc(1); check("R9", "irq cleared", irq[0], 0);

    tag = "R5"; mode_dir(0, 1, 2, 3); m0 = 0;
    for (int k = 0; k < 8; k++) period(5);
    check("R5", "matches in 8 periods ctr2 cpr3", m0, 2);
    mode_dir(0, 1, 5, 3); m0 = 0;
    for (int k = 0; k < 8; k++) period(5);
    check("R5", "target above limit", m0, 0);

    tag = "R6"; mode_dir(0, 1, 0, 0); m0 = 0;
    for (int k = 0; k < 4; k++) period(5);
    check("R6", "every period", m0, 4);

    tag = "R8"; cv = 12; cvm = 0; vupd = 8'h01; cyc(1); vupd = '0; m0 = 0;
    hold(12, 3); check("R8", "shadow not yet applied", m0, 0);
    hold(5, 1); check("R8", "old value still active", m0, 1);
    pe = 1; cyc(1); pe = 0; m0 = 0;
    hold(12, 1); check("R8", "shadow applied at strobe", m0, 1);

    tag = "R10"; mode_dir(1, 1, 0, 0); val_dir(1, 7, 0);
    cnt = 7; cyc(1); cnt = 16'hFFFF;
    check("R10", "event on unit1", ev, 1); check("R10", "no dma unit1", dma, 0);
    cyc(2);

    tag = "R1";
    for (int k = 0; k < 4000; k++) begin
      cnt    = CNT_W'($urandom_range(0, 7));
      down   = 1'($urandom);
      if (($urandom & 63) == 0) center = 1'($urandom);
      pe     = ($urandom_range(0, 3) == 0);
      fault  = ($urandom_range(0, 15) == 0);
      men    = ($urandom_range(0, 7) != 0);
      ctr    = PER_W'($urandom_range(0, 3));
      cpr    = PER_W'($urandom_range(0, 3));
      cv     = CNT_W'($urandom_range(0, 7));
      cvm    = 1'($urandom);
      for (int i = 0; i < N; i++) begin
        mwr[i]  = ($urandom_range(0, 63) == 0);
        mupd[i] = ($urandom_range(0, 15) == 0);
        vwr[i]  = ($urandom_range(0, 63) == 0);
        vupd[i] = ($urandom_range(0, 15) == 0);
        clr[i]  = ($urandom_range(0, 7) == 0);
      end
      cyc(1);
    end
    mwr = '0; mupd = '0; vwr = '0; vupd = '0; clr = '0; pe = 0;
    cyc(2);
    monitor_on = 0;
    summary();
  end

  initial begin
    void'($urandom(32'h5A17));
  end
endmodule